// File: doc/BRIEF.md
# Second-Operand Address and Fetch Unit

This unit turns the lower fields of a 32-bit instruction word into the second operand of an accumulator-style machine that has eight registers. On a start pulse it reads the selected index register through a register-file read port. It adds that value to the sign-extended 16-bit constant taken from the word. It then makes zero, one or two reads of a single-port word memory, as the addressing mode requires. When it finishes, it pulses done and presents two results: the operand value and the effective address.

Every mode adds the index register to the constant. Index register 0 always adds zero. For a store the caller sets a store flag. The unit then makes one fewer memory read than a load in the same mode would make. The address it ends on is the store destination. The unit does not execute the instruction, write back any register or carry store data.

Top module: `opf_unit`

## Requirements
- R1: The index register number sits in instruction bits 18:16 and is driven on `rf_addr`. The mode sits in bits 20:19. The constant sits in bits 15:0. The index value is sampled in the cycle that start is accepted. Bits 31:21 have no effect.
- R2: Mode 0 (add constant and index) makes no memory read. Done pulses one cycle after start. Operand and effective address both equal the sum.
- R3: Mode 1 with the store flag low reads the sum address once, in the first cycle after start. The read data arrives one cycle after the read. Done follows in the third cycle. The operand is the word read, and the effective address is the sum.
- R4: Mode 2 with the store flag low reads the sum address in cycle 1. It then reads the returned word as an address in cycle 3. Done comes in cycle 5. The operand is the second word read, and the effective address is the first word read.
- R5: When the index field is 0, the index contributes zero, whatever register 0 holds.
- R6: The constant is sign-extended from 16 bits before the addition, so 0xFFF0 adds -16.
- R7: Address arithmetic wraps modulo 2^32.
- R8: With the store flag high, one fewer read is made. Mode 1 makes no read and finishes in cycle 1. Mode 2 makes one read and finishes in cycle 3, with the word read as the address. Mode 0 makes no read. In every store case the operand equals the effective address.
- R9: Mode 3 is reserved. It makes no read and pulses done in cycle 1 with `illegal` high. Operand and effective address equal the sum. `illegal` is low at all other times.
- R10: Start is ignored from acceptance through the done cycle. Changing the instruction or the store flag during that time does not alter the reads or the results.
- R11: Done is a one-cycle pulse. Operand and effective address hold their values from done until the next accepted start.
- R12: After reset, done, the read strobe and `illegal` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin operand formation (accepted when idle) |
| instr | input | 32 | Instruction word |
| is_store | input | 1 | Operand is a store destination |
| rf_addr | output | 3 | Register-file read index |
| rf_data | input | 32 | Register-file read data (combinational) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory data, valid the cycle after `mem_rd` |
| done | output | 1 | Result valid pulse |
| operand | output | 32 | Second operand value |
| eff_addr | output | 32 | Effective address |
| illegal | output | 1 | Reserved mode flag, valid with done |

## Verification
A new start can meet the unit while it is still finishing the previous one: start may be held high through the reads and the done cycle, while the instruction and store flag change to unrelated values. The bench provokes this with a held start on an indirect load. On every cycle it compares the read strobe, the read address, done and the results with its own cycle model. A correct unit ignores the held start, keeps the original walk, and accepts only a start seen after it is idle again.

// File: rtl/opf_pkg.sv
package opf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } opf_state_e;

   localparam logic [1:0] AM_SUM  = 2'd0;
   localparam logic [1:0] AM_ONE  = 2'd1;
   localparam logic [1:0] AM_TWO  = 2'd2;
   localparam logic [1:0] AM_RSVD = 2'd3;
endpackage

// File: rtl/opf_index_add.sv
module opf_index_add #(
   parameter int DATA_W   = 32,
   parameter int CONST_W  = 16,
   parameter int RIDX_W   = 3,
   parameter bit ZERO_IDX = 1'b1
) (
   input  logic [RIDX_W-1:0]  idx_sel,
   input  logic [DATA_W-1:0]  idx_val,
   input  logic [CONST_W-1:0] konst,
   output logic [DATA_W-1:0]  sum
);
   logic [DATA_W-1:0] ext;
   logic [DATA_W-1:0] contrib;

   generate
      if (CONST_W > DATA_W) begin : g_bad_w
         $error("opf_index_add: CONST_W exceeds DATA_W");
      end
      if (CONST_W < DATA_W) begin : g_sext
         assign ext = {{(DATA_W-CONST_W){konst[CONST_W-1]}}, konst};
      end else begin : g_full
         assign ext = konst[DATA_W-1:0];
      end
      if (ZERO_IDX) begin : g_zero
         assign contrib = (idx_sel == '0) ? '0 : idx_val;
      end else begin : g_plain
         assign contrib = idx_val;
      end
   endgenerate

   assign sum = ext + contrib;
endmodule

// File: rtl/opf_depth.sv
module opf_depth (
   input  logic [1:0] mode,
   input  logic       store,
   output logic [1:0] levels,
   output logic       bad
);
   import opf_pkg::*;

   always_comb begin
      bad    = 1'b0;
      levels = 2'd0;
      case (mode)
         AM_SUM:  levels = 2'd0;
         AM_ONE:  levels = store ? 2'd0 : 2'd1;
         AM_TWO:  levels = store ? 2'd1 : 2'd2;
         default: bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/opf_walk.sv
module opf_walk #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] base,
   input  logic [1:0]        levels,
   input  logic              store,
   input  logic              bad,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic [DATA_W-1:0] mem_addr,
   output logic              done,
   output logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] eff_addr,
   output logic              illegal
);
   import opf_pkg::*;

   opf_state_e        state;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] opnd_q;
   logic [1:0]        left_q;
   logic              store_q;
   logic              bad_q;
   logic              accept;

   assign accept = (state == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         opnd_q  <= '0;
         left_q  <= '0;
         store_q <= 1'b0;
         bad_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               addr_q  <= base;
               opnd_q  <= base;
               left_q  <= levels;
               store_q <= store;
               bad_q   <= bad;
               state   <= (levels == 2'd0) ? ST_DONE : ST_READ;
            end
            ST_READ: state <= ST_WAIT;
            ST_WAIT: begin
               if (left_q == 2'd1) begin
                  opnd_q <= mem_rdata;
                  if (store_q) addr_q <= mem_rdata;
                  state <= ST_DONE;
               end else begin
                  addr_q <= mem_rdata;
                  left_q <= 2'(left_q - 2'd1);
                  state  <= ST_READ;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd   = (state == ST_READ);
   assign mem_addr = addr_q;
   assign done     = (state == ST_DONE);
   assign operand  = opnd_q;
   assign eff_addr = addr_q;
   assign illegal  = done && bad_q;

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3
   rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (!mem_rd && !done));
   // R9
   illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);
   // R2
   zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && levels == 2'd0) |=> (done && !mem_rd));
   // R11
   hold_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start) |=> ($stable(eff_addr) && $stable(operand)));
   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READ) |=> $stable(mem_addr));
endmodule

// File: rtl/opf_unit.sv
module opf_unit #(
   parameter int INSTR_W  = 32,
   parameter int DATA_W   = 32,
   parameter int CONST_W  = 16,
   parameter int RIDX_W   = 3,
   parameter bit ZERO_IDX = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [INSTR_W-1:0] instr,
   input  logic               is_store,
   output logic [RIDX_W-1:0]  rf_addr,
   input  logic [DATA_W-1:0]  rf_data,
   output logic               mem_rd,
   output logic [DATA_W-1:0]  mem_addr,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               done,
   output logic [DATA_W-1:0]  operand,
   output logic [DATA_W-1:0]  eff_addr,
   output logic               illegal
);
   localparam int RI_LSB   = CONST_W;
   localparam int MODE_LSB = RI_LSB + RIDX_W;
   localparam int USED_W   = MODE_LSB + 2;

   generate
      if (INSTR_W < USED_W + RIDX_W) begin : g_bad_instr
         $error("opf_unit: INSTR_W too narrow for its fields");
      end
   endgenerate

   logic [CONST_W-1:0] konst;
   logic [1:0]         mode;
   logic [DATA_W-1:0]  base;
   logic [1:0]         levels;
   logic               bad;
   logic               unused_hi;

   assign konst     = instr[CONST_W-1:0];
   assign rf_addr   = instr[RI_LSB +: RIDX_W];
   assign mode      = instr[MODE_LSB +: 2];
   assign unused_hi = ^instr[INSTR_W-1:USED_W];

   opf_index_add #(
      .DATA_W(DATA_W), .CONST_W(CONST_W), .RIDX_W(RIDX_W), .ZERO_IDX(ZERO_IDX)
   ) u_add (
      .idx_sel(rf_addr), .idx_val(rf_data), .konst(konst), .sum(base)
   );

   opf_depth u_depth (
      .mode(mode), .store(is_store), .levels(levels), .bad(bad)
   );

   opf_walk #(.DATA_W(DATA_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(start), .base(base), .levels(levels),
      .store(is_store), .bad(bad), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .done(done), .operand(operand),
      .eff_addr(eff_addr), .illegal(illegal)
   );
endmodule

// File: tb/opf_unit_test.sv
`timescale 1ns/1ps
module opf_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic        is_store = 1'b0;
   logic [2:0]  rf_addr;
   logic [31:0] rf_data;
   logic        mem_rd;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata = 32'hDEAD_BEEF;
   logic        done;
   logic [31:0] operand;
   logic [31:0] eff_addr;
   logic        illegal;
   logic [31:0] rf [8];
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          finished = 0;

   always #5 clk = ~clk;

   opf_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .is_store(is_store), .rf_addr(rf_addr), .rf_data(rf_data),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .done(done), .operand(operand), .eff_addr(eff_addr), .illegal(illegal)
   );

   assign rf_data = rf[rf_addr];

   function automatic logic [31:0] mf(logic [31:0] a);
      return (a ^ 32'hA5A5_0000) + 32'h0000_1357;
   endfunction

   always @(posedge clk) mem_rdata <= mem_rd ? mf(mem_addr) : 32'hDEAD_BEEF;

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run(logic [1:0] mode, logic [2:0] ri, logic [15:0] k,
                      bit st, bit hold, string req);
      logic [31:0] a, op, ef;
      logic [31:0] ra [2];
      int n, lat;
      bit ill;
      ill = (mode == 2'd3);
      n = (mode == 2'd1) ? (st ? 0 : 1) : (mode == 2'd2) ? (st ? 1 : 2) : 0;
      a = {{16{k[15]}}, k} + ((ri == 3'd0) ? 32'd0 : rf[ri]);
      op = a; ef = a;
      for (int i = 0; i < n; i++) begin
         ra[i] = a;
         if (i == n - 1 && !st) begin op = mf(a); ef = a; end
         else begin a = mf(a); op = a; ef = a; end
      end
      lat = 2 * n + 1;
      instr = {8'h5C, 3'd5, mode, ri, k};
      is_store = st;
      start = 1'b1;
      for (int c = 1; c <= lat + 1; c++) begin
         bit er;
         @(negedge clk);
         er = (c <= 2 * n - 1) && (c % 2 == 1);
         chk(mem_rd == er, {req, " R1 read strobe"}, 32'(mem_rd), 32'(er));
         if (er) chk(mem_addr == ra[(c-1)/2], {req, " R1 read address"}, mem_addr, ra[(c-1)/2]);
         chk(done == (c == lat), {req, " R11 done"}, 32'(done), 32'(c == lat));
         chk(illegal == (ill && c == lat), {req, " R9 illegal"}, 32'(illegal), 32'(ill && c == lat));
         if (c >= lat) begin
            chk(operand == op, {req, " operand"}, operand, op);
            chk(eff_addr == ef, {req, " eff_addr"}, eff_addr, ef);
         end
         if (hold && c < lat + 1) begin
            instr = ~instr;
            is_store = ~is_store;
         end else start = 1'b0;
      end
   endtask

   initial begin
      for (int i = 0; i < 8; i++) rf[i] = 32'h0100_0000 * i + 32'h40 * i;
      rf[0] = 32'h0000_0777;
      rf[4] = 32'hFFFF_FFF0;
      repeat (3) @(negedge clk);
      chk(!done && !mem_rd && !illegal, "R12 reset outputs", {29'd0, done, mem_rd, illegal}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run(2'd0, 3'd3, 16'h0005, 0, 0, "R2 sum mode");
      run(2'd0, 3'd0, 16'h0123, 0, 0, "R5 zero index");
      run(2'd0, 3'd2, 16'hFFF0, 0, 0, "R6 negative constant");
      run(2'd1, 3'd4, 16'h0020, 0, 0, "R7 wrap");
      run(2'd1, 3'd1, 16'h0010, 0, 0, "R3 single read");
      run(2'd2, 3'd5, 16'h0008, 0, 0, "R4 double read");
      run(2'd2, 3'd0, 16'h8000, 0, 0, "R4 R5 R6 indirect from zero index");
      run(2'd1, 3'd6, 16'h0003, 1, 0, "R8 store one");
      run(2'd2, 3'd7, 16'h0011, 1, 0, "R8 store two");
      run(2'd0, 3'd2, 16'h0001, 1, 0, "R8 store sum");
      run(2'd3, 3'd3, 16'h0042, 0, 0, "R9 reserved");
      run(2'd2, 3'd2, 16'h0100, 0, 1, "R10 held start");
      run(2'd1, 3'd3, 16'h0004, 0, 0, "R10 after held start");
      run(2'd3, 3'd0, 16'hFFFF, 1, 1, "R9 R10 reserved held");
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule